// File: doc/BRIEF.md
# LIN Byte Buffer and Status Flags

This block sits in a LIN serial controller between a simple register bus and the byte-level shifter. It holds one byte waiting to be transmitted and one byte already received. It also gathers line events into an 8-bit status word, and most of that word's flags clear when the status is read. Software writes the data port to queue a transmit byte and reads the same port to collect a received byte. The shifter takes queued bytes and delivers received bytes through strobes.

A bus monitor reports three kinds of event: a detected break/sync field, an inactivity timeout, and a bit comparison made while transmitting. For the comparison it gives the bit that was driven and the bit that was sampled back. A readback mismatch lands in one of two separate flags, depending on its direction. When a buffer is full, new data is rejected and the buffer keeps what it holds. The byte already held is never overwritten.

Top module: `lin_bufstat`

## Requirements
- R1: After a synchronous reset the 32-bit status readout is 0x00000004, so only bit 2 (TX empty) is set, and `tx_avail` is low. Bits 31:8 of the readout are always 0.
- R2: A `data_wr` while the TX buffer is empty stores `wr_data`, clears status bit 2 and raises `tx_avail` with the byte on `tx_byte`. A `tx_take` while the buffer is full sets bit 2 again. A `tx_take` while the buffer is empty has no effect.
- R3: A `data_wr` while the TX buffer is full, with no `tx_take` in the same cycle, is discarded. The buffered byte is kept and status bit 5 (write collision) is set.
- R4: An `rx_load` while the RX buffer is empty stores `rx_byte` on `rd_data` and sets status bit 1. Only `data_rd` clears bit 1; a status read does not.
- R5: An `rx_load` while the RX buffer is full, with no `data_rd` in the same cycle, is discarded. The old byte stays on `rd_data` and status bit 4 (RX overflow) is set.
- R6: A `brk_det` pulse sets status bit 0.
- R7: With `tx_active` and `bit_sample` both high, a driven 1 (`bit_sent`) that is sampled as 0 (`bit_seen`) sets status bit 3 (conflict). When either of those two inputs is low, no comparison is made.
- R8: With `tx_active` and `bit_sample` both high, a driven 0 that is sampled as 1 sets status bit 6 (driver off). Matching bits set nothing.
- R9: An `idle_expire` pulse sets status bit 7.
- R10: A `stat_rd` clears bits 0, 3, 4, 5, 6 and 7 at the following clock edge. Bits 1 and 2 follow buffer occupancy only.
- R11: When a set event and a `stat_rd` occur in the same cycle for one flag, that flag ends up set.
- R12: A `data_wr` in the same cycle as a `tx_take` is accepted, and so is an `rx_load` in the same cycle as a `data_rd`. In both cases the new byte replaces the old one and no collision or overflow is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| data_wr | input | 1 | Bus write strobe for the data port (loads the TX buffer) |
| wr_data | input | 8 | Byte written to the data port |
| data_rd | input | 1 | Bus read strobe for the data port (frees the RX buffer) |
| rd_data | output | 8 | Content of the RX buffer |
| stat_rd | input | 1 | Bus read strobe for the status word |
| status | output | 32 | Status readout; bits 31:8 are zero |
| tx_take | input | 1 | Shifter takes the buffered transmit byte |
| tx_byte | output | 8 | Content of the TX buffer |
| tx_avail | output | 1 | TX buffer holds a byte |
| rx_load | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte from the shifter |
| brk_det | input | 1 | Break/sync field detected |
| tx_active | input | 1 | Transmitter is sending a frame |
| bit_sample | input | 1 | Bit comparison strobe |
| bit_sent | input | 1 | Level that was driven |
| bit_seen | input | 1 | Level that was sampled back |
| idle_expire | input | 1 | Inactivity timeout expired |

## Verification
The in-RTL assertions check several rules on every cycle: a set event always leaves its flag set, and a status read with no event clears it. A rejected write or load must leave the buffer unchanged, an accepted byte must appear one cycle later, the conflict flag never rises outside transmission, and reset yields 0x04. Other behaviour only the bench scenarios show. These cover the exact status values across sequences of events, and the fact that a status read leaves RX full alone. They also cover the same-cycle cases where a read frees a buffer for new data, or an event beats a clearing read, along with taking from an empty TX buffer and bit comparisons without the strobe.

// File: rtl/lin_bufstat_pkg.sv
package lin_bufstat_pkg;

    localparam int DATA_W   = 8;
    localparam int BUS_W    = 32;
    localparam int N_STICKY = 6;

    // Sticky event indices inside the flag bank
    localparam int EV_SYNC  = 0;
    localparam int EV_CONF  = 1;
    localparam int EV_OVF   = 2;
    localparam int EV_COLL  = 3;
    localparam int EV_DOFF  = 4;
    localparam int EV_IDLE  = 5;

    // Status layout, msb first; bit positions are visible to software
    typedef struct packed {
        logic inactive;  // 7
        logic drv_off;   // 6
        logic wr_coll;   // 5
        logic rx_ovf;    // 4
        logic conflict;  // 3
        logic tx_empty;  // 2
        logic rx_full;   // 1
        logic sync_seen; // 0
    } status_t;

    localparam int STAT_W = $bits(status_t);

    typedef enum logic [1:0] {
        CMP_MATCH    = 2'd0,
        CMP_CONFLICT = 2'd1,
        CMP_DRVOFF   = 2'd2
    } cmp_e;

    function automatic cmp_e bit_compare(input logic sent, input logic seen);
        if (sent == seen)
            return CMP_MATCH;
        else if (sent)
            return CMP_CONFLICT;
        else
            return CMP_DRVOFF;
    endfunction

endpackage

// File: rtl/lin_txbuf.sv
module lin_txbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_data,
    input  logic         take,
    output logic [W-1:0] data,
    output logic         empty,
    output logic         coll_ev
);
    logic accept;

    assign accept  = wr && (empty || take);
    assign coll_ev = wr && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            empty <= 1'b1;
        end else if (accept) begin
            data  <= wr_data;
            empty <= 1'b0;
        end else if (take) begin
            empty <= 1'b1;
        end
    end

    // R3
    tx_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && !empty && !take) |=> ($stable(data) && !empty));

    // R12
    tx_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && (empty || take)) |=> (data == $past(wr_data) && !empty));

endmodule

// File: rtl/lin_rxbuf.sv
module lin_rxbuf #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         rd,
    output logic [W-1:0] data,
    output logic         full,
    output logic         ovf_ev
);
    logic accept;

    assign accept = load && (!full || rd);
    assign ovf_ev = load && !accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
            full <= 1'b0;
        end else if (accept) begin
            data <= load_data;
            full <= 1'b1;
        end else if (rd) begin
            full <= 1'b0;
        end
    end

    // R5
    rx_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (load && full && !rd) |=> ($stable(data) && full));

    // R4
    rx_store_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !full) |=> (data == $past(load_data) && full));

endmodule

// File: rtl/lin_bitcmp.sv
module lin_bitcmp
    import lin_bufstat_pkg::*;
(
    input  logic active,
    input  logic strobe,
    input  logic sent,
    input  logic seen,
    output logic conf_ev,
    output logic doff_ev
);
    cmp_e verdict;

    always_comb begin
        verdict = bit_compare(sent, seen);
        conf_ev = 1'b0;
        doff_ev = 1'b0;
        if (active && strobe) begin
            conf_ev = (verdict == CMP_CONFLICT);
            doff_ev = (verdict == CMP_DRVOFF);
        end
    end

    // R7, R8
    always_comb begin
        cmp_excl_chk: assert (!(conf_ev && doff_ev));
    end

endmodule

// File: rtl/lin_flagbank.sv
module lin_flagbank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_ev,
    input  logic         clr_rd,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else if (set_ev[i])
                flags[i] <= 1'b1;
            else if (clr_rd)
                flags[i] <= 1'b0;
        end

        // R11
        set_wins_chk: assert property (@(posedge clk) disable iff (rst)
            set_ev[i] |=> flags[i]);

        // R10
        rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (clr_rd && !set_ev[i]) |=> !flags[i]);
    end

endmodule

// File: rtl/lin_bufstat.sv
module lin_bufstat
    import lin_bufstat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              data_rd,
    output logic [DATA_W-1:0] rd_data,
    input  logic              stat_rd,
    output logic [BUS_W-1:0]  status,
    input  logic              tx_take,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_avail,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              brk_det,
    input  logic              tx_active,
    input  logic              bit_sample,
    input  logic              bit_sent,
    input  logic              bit_seen,
    input  logic              idle_expire
);
    localparam int PAD_W = BUS_W - STAT_W;

    logic                tx_empty, rx_full;
    logic                coll_ev, ovf_ev, conf_ev, doff_ev;
    logic [N_STICKY-1:0] set_ev, sticky;
    status_t             st;

    lin_txbuf #(.W(DATA_W)) i_tx (
        .clk(clk), .rst(rst), .wr(data_wr), .wr_data(wr_data), .take(tx_take),
        .data(tx_byte), .empty(tx_empty), .coll_ev(coll_ev)
    );

    lin_rxbuf #(.W(DATA_W)) i_rx (
        .clk(clk), .rst(rst), .load(rx_load), .load_data(rx_byte), .rd(data_rd),
        .data(rd_data), .full(rx_full), .ovf_ev(ovf_ev)
    );

    lin_bitcmp i_cmp (
        .active(tx_active), .strobe(bit_sample), .sent(bit_sent), .seen(bit_seen),
        .conf_ev(conf_ev), .doff_ev(doff_ev)
    );

    always_comb begin
        set_ev          = '0;
        set_ev[EV_SYNC] = brk_det;
        set_ev[EV_CONF] = conf_ev;
        set_ev[EV_OVF]  = ovf_ev;
        set_ev[EV_COLL] = coll_ev;
        set_ev[EV_DOFF] = doff_ev;
        set_ev[EV_IDLE] = idle_expire;
    end

    lin_flagbank #(.N(N_STICKY)) i_flags (
        .clk(clk), .rst(rst), .set_ev(set_ev), .clr_rd(stat_rd), .flags(sticky)
    );

    always_comb begin
        st.sync_seen = sticky[EV_SYNC];
        st.rx_full   = rx_full;
        st.tx_empty  = tx_empty;
        st.conflict  = sticky[EV_CONF];
        st.rx_ovf    = sticky[EV_OVF];
        st.wr_coll   = sticky[EV_COLL];
        st.drv_off   = sticky[EV_DOFF];
        st.inactive  = sticky[EV_IDLE];
    end

    assign status   = {{PAD_W{1'b0}}, st};
    assign tx_avail = !tx_empty;

    // R1
    reset_val_chk: assert property (@(posedge clk)
        rst |=> (status[STAT_W-1:0] == 8'h04 && !tx_avail));

    // R7
    no_conf_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && !status[3]) |=> !status[3]);

    // R8
    no_doff_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!tx_active && !status[6]) |=> !status[6]);

endmodule

// File: tb/test_lin_bufstat.sv
module test_lin_bufstat;
    logic        clk = 1'b0;
    logic        rst;
    logic        data_wr, data_rd, stat_rd, tx_take, rx_load;
    logic [7:0]  wr_data, rx_byte, rd_data, tx_byte;
    logic [31:0] status;
    logic        tx_avail, brk_det, tx_active, bit_sample, bit_sent, bit_seen, idle_expire;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    typedef struct {
        string       tag;
        int          sel;   // 0 status, 1 rd_data, 2 tx_byte, 3 tx_avail
        logic [31:0] exp;
    } item_t;
    item_t q[$];

    always #4 clk = ~clk;

    lin_bufstat i_lin_bufstat (
        .clk(clk), .rst(rst), .data_wr(data_wr), .wr_data(wr_data), .data_rd(data_rd),
        .rd_data(rd_data), .stat_rd(stat_rd), .status(status), .tx_take(tx_take),
        .tx_byte(tx_byte), .tx_avail(tx_avail), .rx_load(rx_load), .rx_byte(rx_byte),
        .brk_det(brk_det), .tx_active(tx_active), .bit_sample(bit_sample),
        .bit_sent(bit_sent), .bit_seen(bit_seen), .idle_expire(idle_expire)
    );

    task automatic quiet();
        data_wr = 0; data_rd = 0; stat_rd = 0; tx_take = 0; rx_load = 0;
        wr_data = 8'h00; rx_byte = 8'h00; brk_det = 0; tx_active = 0;
        bit_sample = 0; bit_sent = 0; bit_seen = 0; idle_expire = 0;
    endtask

    task automatic push(input string tag, input int sel, input logic [31:0] exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        q.push_back(it);
    endtask

    // Driver: inputs are set at a negedge beforehand; wait the edge, queue expectations
    task automatic tick_stat(input string tag, input logic [31:0] exp);
        @(posedge clk);
        push(tag, 0, exp);
        @(negedge clk);
        quiet();
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: compares queued expectations shortly after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.sel)
                    0: act = status;
                    1: act = {24'h0, rd_data};
                    2: act = {24'h0, tx_byte};
                    default: act = {31'h0, tx_avail};
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(8 * 5000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            finish_run();
        end
    end

    initial begin
        quiet();
        rst = 1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;
        push("R1 reset status", 0, 32'h4);
        push("R1 reset tx_avail", 3, 0);
        @(posedge clk);

        // R2 load into empty TX buffer
        @(negedge clk); data_wr = 1; wr_data = 8'hA5;
        @(posedge clk);
        push("R2 tx load status", 0, 32'h0);
        push("R2 tx load byte", 2, 32'hA5);
        push("R2 tx load avail", 3, 1);
        @(negedge clk); quiet();

        // R3 write collision
        data_wr = 1; wr_data = 8'h3C;
        @(posedge clk);
        push("R3 collision status", 0, 32'h20);
        push("R3 collision keeps byte", 2, 32'hA5);
        @(negedge clk); quiet();

        // R10 clear on read
        stat_rd = 1; tick_stat("R10 collision cleared", 32'h0);

        // R2 take, then take from empty
        tx_take = 1; tick_stat("R2 take sets empty", 32'h4);
        push("R2 avail low", 3, 0);
        tx_take = 1; tick_stat("R2 take on empty ignored", 32'h4);

        // R4 RX load, status read keeps RX full
        rx_load = 1; rx_byte = 8'h5A;
        @(posedge clk);
        push("R4 rx full", 0, 32'h6);
        push("R4 rx data", 1, 32'h5A);
        @(negedge clk); quiet();
        stat_rd = 1; tick_stat("R4 status read keeps rx full", 32'h6);

        // R5 overflow
        rx_load = 1; rx_byte = 8'h77;
        @(posedge clk);
        push("R5 overflow status", 0, 32'h16);
        push("R5 old byte kept", 1, 32'h5A);
        @(negedge clk); quiet();
        data_rd = 1; tick_stat("R4 data read clears rx full", 32'h14);
        stat_rd = 1; tick_stat("R10 overflow cleared", 32'h4);

        // R6 break
        brk_det = 1; tick_stat("R6 break flag", 32'h5);
        stat_rd = 1; tick_stat("R10 break cleared", 32'h4);

        // R7 conflict
        bit_sample = 1; bit_sent = 1; bit_seen = 0;
        tick_stat("R7 no compare when idle", 32'h4);
        tx_active = 1; bit_sent = 1; bit_seen = 0;
        tick_stat("R7 no compare without strobe", 32'h4);
        tx_active = 1; bit_sample = 1; bit_sent = 1; bit_seen = 0;
        tick_stat("R7 conflict flag", 32'hC);
        stat_rd = 1; tick_stat("R10 conflict cleared", 32'h4);

        // R8 driver off
        tx_active = 1; bit_sample = 1; bit_sent = 0; bit_seen = 1;
        tick_stat("R8 driver off flag", 32'h44);
        stat_rd = 1; tick_stat("R10 driver off cleared", 32'h4);
        tx_active = 1; bit_sample = 1; bit_sent = 1; bit_seen = 1;
        tick_stat("R8 match sets nothing", 32'h4);

        // R9 inactivity, R11 set beats clear
        idle_expire = 1; tick_stat("R9 inactive flag", 32'h84);
        idle_expire = 1; stat_rd = 1; tick_stat("R11 set wins over read", 32'h84);
        stat_rd = 1; brk_det = 1; tick_stat("R11 break during read", 32'h5);
        stat_rd = 1; tick_stat("R10 all cleared", 32'h4);

        // R12 same-cycle write with take
        data_wr = 1; wr_data = 8'h11; tick_stat("R12 first write", 32'h0);
        data_wr = 1; wr_data = 8'h22; tx_take = 1;
        @(posedge clk);
        push("R12 write with take status", 0, 32'h0);
        push("R12 write with take byte", 2, 32'h22);
        @(negedge clk); quiet();

        // R12 same-cycle load with read
        rx_load = 1; rx_byte = 8'h33; tick_stat("R12 first load", 32'h2);
        rx_load = 1; rx_byte = 8'h44; data_rd = 1;
        @(posedge clk);
        push("R12 load with read status", 0, 32'h2);
        push("R12 load with read byte", 1, 32'h44);
        @(negedge clk); quiet();
        tx_take = 1; tick_stat("R2 final take", 32'h6);
        data_rd = 1; tick_stat("R4 final read", 32'h4);

        @(posedge clk);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule